// File: doc/BRIEF.md
# FP Instruction Repeat Sequencer

This block sits between the decode stage and the floating-point execution pipeline. Decoded instructions come in one at a time with a flag that marks them as floating-point or integer. Integer instructions always go straight on to the integer pipeline. When no loop is active, floating-point instructions go straight on to the FP issue port.

A repeat command gives a body length and an iteration count. After such a command, the sequencer takes the next `length` floating-point instructions from decode into a small buffer and does not issue them. Once the body is complete, it replays the buffer on its own, `iteration count` times over, in program order. While it does this, decode keeps delivering integer instructions, so the integer stream and the FP stream advance in parallel. Any value that passes between the two domains has to go through memory or a queue. The sequencer never reads or writes a register file.

While the sequencer is filling or replaying, it reports busy and holds off any new repeat command. It also stalls any further floating-point instruction from decode, so FP program order is kept. A malformed command is dropped and flagged.

Top module: `fp_repeat_seq`

## Requirements
- R1: When idle, an FP instruction (`instr_is_fp_i`=1) is presented on `fp_valid_o`/`fp_data_o` unchanged. Its `instr_ready_o` follows `fp_ready_i`.
- R2: In every state, an integer instruction (`instr_is_fp_i`=0) is presented on `int_valid_o`/`int_data_o`, and `instr_ready_o` equals `int_ready_i`.
- R3: A command accepted with length 1..16 and a nonzero count sets `busy_o` in the next cycle. The next `length` FP instructions are taken with `instr_ready_o`=1, and none of them appears on the FP issue port during the fill.
- R4: A command accepted with length 0, length above 16 (the 5-bit field can carry up to 31), or count 0 raises `err_o` for exactly the next cycle. It leaves `busy_o` low, and later FP instructions pass straight through.
- R5: Replay issues body slots 0..length-1 in order, then wraps to slot 0, for length × count issues in total. `busy_o` clears after the last issue handshake.
- R6: While `fp_ready_i` is low, `fp_valid_o` stays high and `fp_data_o` stays unchanged. No slot is skipped or issued twice.
- R7: `cfg_ready_o` is low whenever `busy_o` is high, and a command presented during that time has no effect.
- R8: During replay, an FP instruction from decode is held (`instr_ready_o`=0) until `busy_o` clears. It is then passed through after the replay, in order.
- R9: After reset, `busy_o`=0, `err_o`=0 and `cfg_ready_o`=1, and `fp_valid_o`=0 when no instruction is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Repeat command valid |
| cfg_ready_o | output | 1 | Repeat command accepted (idle) |
| cfg_len_i | input | 5 | Body length in instructions |
| cfg_iter_i | input | 16 | Number of body iterations |
| err_o | output | 1 | One-cycle pulse for a rejected command |
| instr_valid_i | input | 1 | Decoded instruction valid |
| instr_ready_o | output | 1 | Decoded instruction taken |
| instr_data_i | input | 32 | Instruction word |
| instr_is_fp_i | input | 1 | 1 = floating-point instruction |
| int_valid_o | output | 1 | Integer issue valid |
| int_ready_i | input | 1 | Integer pipeline ready |
| int_data_o | output | 32 | Integer instruction word |
| fp_valid_o | output | 1 | FP issue valid |
| fp_ready_i | input | 1 | FP pipeline ready |
| fp_data_o | output | 32 | FP instruction word |
| busy_o | output | 1 | Filling or replaying |

## Verification
The bench aims at the wrap from the last body slot back to slot 0 and at the end of the iteration count. A design with an off-by-one would issue one body slot too many or too few, or would free busy early. Random FP back-pressure during replay shows any slot that is dropped or issued twice under a stall. The boundary lengths 1 and 16 are run, and so are the rejected cases of length 0, length 17 and count 0. A design that takes these rejected commands would hang in fill or swallow the next FP instruction. While a replay is running, the bench sends integer instructions, a repeat command and an FP instruction from decode. A wrong design would stall the integer stream, restart the loop, or interleave the late FP instruction with the replay.

// File: rtl/fprep_pkg.sv
package fprep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PLAY = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fprep_buffer.sv
module fprep_buffer #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  slot_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(g))       slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/fprep_ctrl.sv
module fprep_ctrl
  import fprep_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ITER_W = 16,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic [ITER_W-1:0] cfg_iter_i,
  output logic              cfg_ready_o,
  output logic              err_o,
  input  logic              cap_fire_i,
  input  logic              play_fire_i,
  output seq_state_e        state_o,
  output logic [IW-1:0]     wr_idx_o,
  output logic [IW-1:0]     rd_idx_o
);
  seq_state_e        state_q;
  logic [LEN_W-1:0]  len_q;
  logic [ITER_W-1:0] iter_q;
  logic [IW-1:0]     wr_q, rd_q;
  logic              err_q;

  logic cfg_fire, cfg_ok, wr_last, rd_last;

  assign cfg_ready_o = (state_q == ST_IDLE);
  assign cfg_fire    = cfg_valid_i && cfg_ready_o;
  assign cfg_ok      = (cfg_len_i != '0) && (cfg_len_i <= LEN_W'(DEPTH)) && (cfg_iter_i != '0);
  assign wr_last     = (LEN_W'(wr_q) + LEN_W'(1)) == len_q;
  assign rd_last     = (LEN_W'(rd_q) + LEN_W'(1)) == len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      iter_q  <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= cfg_fire && !cfg_ok;
      unique case (state_q)
        ST_IDLE: if (cfg_fire && cfg_ok) begin
          state_q <= ST_FILL;
          len_q   <= cfg_len_i;
          iter_q  <= cfg_iter_i;
          wr_q    <= '0;
          rd_q    <= '0;
        end
        ST_FILL: if (cap_fire_i) begin
          if (wr_last) state_q <= ST_PLAY;
          else         wr_q    <= wr_q + IW'(1);
        end
        ST_PLAY: if (play_fire_i) begin
          if (rd_last) begin
            rd_q <= '0;
            if (iter_q == ITER_W'(1)) state_q <= ST_IDLE;
            else                      iter_q  <= iter_q - ITER_W'(1);
          end else begin
            rd_q <= rd_q + IW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign wr_idx_o = wr_q;
  assign rd_idx_o = rd_q;
  assign err_o    = err_q;
endmodule

// File: rtl/fprep_steer.sv
module fprep_steer
  import fprep_pkg::*;
#(
  parameter int DW = 32
) (
  input  seq_state_e    state_i,
  input  logic          instr_valid_i,
  input  logic [DW-1:0] instr_data_i,
  input  logic          instr_is_fp_i,
  output logic          instr_ready_o,
  input  logic [DW-1:0] buf_data_i,
  output logic          cap_fire_o,
  output logic          play_fire_o,
  output logic          int_valid_o,
  input  logic          int_ready_i,
  output logic [DW-1:0] int_data_o,
  output logic          fp_valid_o,
  input  logic          fp_ready_i,
  output logic [DW-1:0] fp_data_o
);
  logic fp_in, fp_take;

  assign fp_in       = instr_valid_i && instr_is_fp_i;
  assign int_valid_o = instr_valid_i && !instr_is_fp_i;
  assign int_data_o  = instr_data_i;

  always_comb begin
    fp_valid_o  = 1'b0;
    fp_data_o   = instr_data_i;
    fp_take     = 1'b0;
    cap_fire_o  = 1'b0;
    play_fire_o = 1'b0;
    unique case (state_i)
      ST_FILL: begin
        fp_take    = 1'b1;
        cap_fire_o = fp_in;
      end
      ST_PLAY: begin
        fp_valid_o  = 1'b1;
        fp_data_o   = buf_data_i;
        play_fire_o = fp_ready_i;
      end
      default: begin
        fp_valid_o = fp_in;
        fp_take    = fp_ready_i;
      end
    endcase
  end

  assign instr_ready_o = instr_is_fp_i ? fp_take : int_ready_i;
endmodule

// File: rtl/fp_repeat_seq.sv
module fp_repeat_seq
  import fprep_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DEPTH  = 16,
  parameter int ITER_W = 16,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  output logic              cfg_ready_o,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic [ITER_W-1:0] cfg_iter_i,
  output logic              err_o,
  input  logic              instr_valid_i,
  output logic              instr_ready_o,
  input  logic [DW-1:0]     instr_data_i,
  input  logic              instr_is_fp_i,
  output logic              int_valid_o,
  input  logic              int_ready_i,
  output logic [DW-1:0]     int_data_o,
  output logic              fp_valid_o,
  input  logic              fp_ready_i,
  output logic [DW-1:0]     fp_data_o,
  output logic              busy_o
);
  seq_state_e    state;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [DW-1:0] buf_data;
  logic          cap_fire, play_fire;

  fprep_ctrl #(.DEPTH(DEPTH), .ITER_W(ITER_W)) u_ctrl (
    .clk_i, .rst_ni,
    .cfg_valid_i, .cfg_len_i, .cfg_iter_i, .cfg_ready_o, .err_o,
    .cap_fire_i(cap_fire), .play_fire_i(play_fire),
    .state_o(state), .wr_idx_o(wr_idx), .rd_idx_o(rd_idx)
  );

  fprep_buffer #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk_i, .rst_ni,
    .wr_en_i(cap_fire), .wr_idx_i(wr_idx), .wr_data_i(instr_data_i),
    .rd_idx_i(rd_idx), .rd_data_o(buf_data)
  );

  fprep_steer #(.DW(DW)) u_steer (
    .state_i(state),
    .instr_valid_i, .instr_data_i, .instr_is_fp_i, .instr_ready_o,
    .buf_data_i(buf_data), .cap_fire_o(cap_fire), .play_fire_o(play_fire),
    .int_valid_o, .int_ready_i, .int_data_o,
    .fp_valid_o, .fp_ready_i, .fp_data_o
  );

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/fp_repeat_seq_chk.sv
module fp_repeat_seq_chk #(
  parameter int DW     = 32,
  parameter int DEPTH  = 16,
  parameter int ITER_W = 16,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_valid_i,
  input logic              cfg_ready_o,
  input logic [LEN_W-1:0]  cfg_len_i,
  input logic [ITER_W-1:0] cfg_iter_i,
  input logic              err_o,
  input logic              instr_valid_i,
  input logic              instr_ready_o,
  input logic              instr_is_fp_i,
  input logic              int_valid_o,
  input logic              int_ready_i,
  input logic              fp_valid_o,
  input logic              fp_ready_i,
  input logic [DW-1:0]     fp_data_o,
  input logic              busy_o
);
  logic good_cmd;
  assign good_cmd = (cfg_len_i >= LEN_W'(1)) && (cfg_len_i <= LEN_W'(DEPTH)) && (cfg_iter_i != '0);

  assert_accept_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && cfg_ready_o && good_cmd |=> busy_o);

  assert_reject_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && cfg_ready_o && !good_cmd |=> err_o && !busy_o);

  assert_issue_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_valid_o && !fp_ready_i |=> fp_valid_o && $stable(fp_data_o));

  assert_cfg_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cfg_ready_o);

  assert_fp_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && fp_valid_o && instr_valid_i && instr_is_fp_i |-> !instr_ready_o);

  assert_int_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && !instr_is_fp_i |-> int_valid_o && (instr_ready_o == int_ready_i));
endmodule

bind fp_repeat_seq fp_repeat_seq_chk #(.DW(DW), .DEPTH(DEPTH), .ITER_W(ITER_W)) u_chk (
  .clk_i, .rst_ni, .cfg_valid_i, .cfg_ready_o, .cfg_len_i, .cfg_iter_i, .err_o,
  .instr_valid_i, .instr_ready_o, .instr_is_fp_i, .int_valid_o, .int_ready_i,
  .fp_valid_o, .fp_ready_i, .fp_data_o, .busy_o
);

// File: tb/fp_repeat_seq_tb.sv
module fp_repeat_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [4:0]  cfg_len = '0;
  logic [15:0] cfg_iter = '0;
  logic        err;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_data = '0;
  logic        instr_fp = 1'b0;
  logic        int_valid;
  logic        int_ready = 1'b1;
  logic [31:0] int_data;
  logic        fp_valid;
  logic        fp_ready = 1'b1;
  logic [31:0] fp_data;
  logic        busy;

  int tests = 0, fails = 0, cyc = 0;
  logic        stall_mode = 1'b0;
  logic [31:0] fp_log [0:511];
  int          fp_cnt = 0;
  logic [31:0] int_last = '0;
  int          int_cnt = 0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_data = '0;

  always #10 clk = ~clk;

  fp_repeat_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_valid_i(cfg_valid), .cfg_ready_o(cfg_ready), .cfg_len_i(cfg_len), .cfg_iter_i(cfg_iter),
    .err_o(err),
    .instr_valid_i(instr_valid), .instr_ready_o(instr_ready), .instr_data_i(instr_data),
    .instr_is_fp_i(instr_fp),
    .int_valid_o(int_valid), .int_ready_i(int_ready), .int_data_o(int_data),
    .fp_valid_o(fp_valid), .fp_ready_i(fp_ready), .fp_data_o(fp_data),
    .busy_o(busy)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // downstream ready pattern and output monitors
  always @(negedge clk) begin
    cyc++;
    fp_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    #5;
    if (prev_stall) chk(fp_valid && fp_data == prev_data, "R6 hold under stall", fp_data, prev_data);
    prev_stall = fp_valid && !fp_ready;
    prev_data  = fp_data;
    if (fp_valid && fp_ready) begin
      if (fp_cnt < 512) fp_log[fp_cnt] = fp_data;
      fp_cnt++;
    end
    if (int_valid && int_ready) begin
      int_last = int_data;
      int_cnt++;
    end
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic send_cfg(input logic [4:0] len, input logic [15:0] it);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_len = len; cfg_iter = it;
    #1;
    while (!cfg_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cfg_valid = 1'b0;
  endtask

  task automatic push(input logic [31:0] d, input logic fp);
    @(negedge clk);
    instr_valid = 1'b1; instr_data = d; instr_fp = fp;
    #1;
    while (!instr_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    instr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk); #1;
    while (busy) begin @(negedge clk); #1; end
    @(negedge clk); #6;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(!busy, "R9 busy after reset", busy, 0);
    chk(!err, "R9 err after reset", err, 0);
    chk(cfg_ready, "R9 cfg_ready after reset", cfg_ready, 1);
    chk(!fp_valid, "R9 fp_valid idle", fp_valid, 0);
  endtask

  task automatic t_pass();
    fp_cnt = 0;
    push(32'hF00D_0001, 1'b1);
    @(negedge clk); #6;
    chk(fp_cnt == 1 && fp_log[0] == 32'hF00D_0001, "R1 idle FP passthrough", fp_log[0], 32'hF00D_0001);
    push(32'h1A7E_0001, 1'b0);
    @(negedge clk); #6;
    chk(int_last == 32'h1A7E_0001, "R2 idle integer passthrough", int_last, 32'h1A7E_0001);
    chk(fp_cnt == 1, "R1 integer not on FP port", fp_cnt, 1);
  endtask

  task automatic run_loop(input int len, input int it, input logic stall, input logic [31:0] base);
    fp_cnt = 0;
    stall_mode = stall;
    send_cfg(5'(len), 16'(it));
    @(negedge clk); #1;
    chk(busy, "R3 busy after accepted command", busy, 1);
    for (int i = 0; i < len; i++) push(base + 32'(i), 1'b1);
    chk(fp_cnt == 0, "R3 no issue during fill", fp_cnt, 0);
    wait_idle();
    stall_mode = 1'b0;
    chk(fp_cnt == len * it, "R5 total issue count", fp_cnt, len * it);
    for (int k = 0; k < len * it && k < 512; k++)
      if (fp_log[k] != base + 32'(k % len)) begin
        chk(1'b0, "R5 replay order", fp_log[k], base + 32'(k % len));
        break;
      end
  endtask

  task automatic t_reject(input logic [4:0] len, input logic [15:0] it);
    fp_cnt = 0;
    send_cfg(len, it);
    @(negedge clk); #1;
    chk(err && !busy, "R4 error pulse on bad command", {err, busy}, 2'b10);
    @(negedge clk); #1;
    chk(!err, "R4 error lasts one cycle", err, 0);
    push(32'hBAD0_0000 | 32'(len), 1'b1);
    @(negedge clk); #6;
    chk(fp_cnt == 1 && fp_log[0] == (32'hBAD0_0000 | 32'(len)), "R4 FP passes after reject",
        fp_log[0], 32'hBAD0_0000 | 32'(len));
  endtask

  task automatic t_concurrent();
    fp_cnt = 0;
    send_cfg(5'd3, 16'd20);
    for (int i = 0; i < 3; i++) push(32'hC000_0000 + 32'(i), 1'b1);
    push(32'h1A7E_0002, 1'b0);
    @(negedge clk); #6;
    chk(int_last == 32'h1A7E_0002 && busy, "R2 integer flows during replay", int_last, 32'h1A7E_0002);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_len = 5'd2; cfg_iter = 16'd1;
    #1;
    chk(!cfg_ready, "R7 command held off while busy", cfg_ready, 0);
    repeat (3) @(negedge clk);
    cfg_valid = 1'b0;
    @(negedge clk);
    instr_valid = 1'b1; instr_data = 32'hDEAD_0001; instr_fp = 1'b1;
    #1;
    chk(!instr_ready, "R8 FP from decode stalled during replay", instr_ready, 0);
    while (!instr_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    instr_valid = 1'b0;
    @(negedge clk); #6;
    chk(fp_cnt == 61, "R7 replay count unchanged by held command", fp_cnt, 61);
    chk(fp_log[60] == 32'hDEAD_0001 && fp_log[59] == 32'hC000_0002, "R8 late FP after replay",
        fp_log[60], 32'hDEAD_0001);
    chk(!busy, "R7 no second loop started", busy, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pass();
    run_loop(3, 2, 1'b0, 32'hA000_0000);
    run_loop(4, 3, 1'b1, 32'hB000_0000);
    run_loop(16, 2, 1'b1, 32'hD000_0000);
    run_loop(1, 5, 1'b0, 32'hE000_0000);
    t_reject(5'd0, 16'd2);
    t_reject(5'd17, 16'd2);
    t_reject(5'd4, 16'd0);
    t_concurrent();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule